// File: doc/BRIEF.md
# Microsequenced Accumulator CPU Core

This block is a small 8-bit processor with a 16-bit address space and a single accumulator. Every instruction is carried out as a fixed chain of one-cycle register-transfer steps. All memory traffic passes through an address register and a data register, and the address register drives the external address bus. Eight opcodes are implemented: direct load, store and add, add immediate, accumulator push and pop, absolute call and return. Every other opcode executes as a do-nothing instruction.

The core talks to a synchronous memory. The core raises a read strobe for one cycle. The memory returns the byte during the following cycle, and the core captures it at the end of that cycle. A write strobe lasts one cycle, and the address and write data are valid during it. The only architectural flag is the carry out of the last add. It is exported so that software-visible arithmetic state can be observed.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, both strobes and the carry output are low. After reset the first read is at address 0x0000. The stack pointer starts at 0xFF00, so the first push writes address 0xFF01.
- R2: An instruction begins with four fetch cycles. The cycles are idle, then a read at the program counter, then two idle cycles, and the program counter advances by one. A carry value set by an earlier add is unchanged at the first fetch cycle of the next instruction.
- R3: Opcodes 0x01, 0x02, 0x03 and 0x07 are followed by a 16-bit address, low byte first. Each operand byte takes four cycles: idle, a read at the program counter, and two idle cycles. For the direct opcodes 0x01, 0x02 and 0x03, two idle cycles then follow while the address is moved byte by byte.
- R4: Direct load (0x01) and direct add (0x03) read the addressed byte, then spend two idle cycles. Load replaces A with the byte. Add replaces A with the low 8 bits of A plus the byte and sets carry to bit 8 of the sum.
- R5: Direct store (0x02) spends one idle cycle and then writes A to the operand address.
- R6: Add immediate (0x04) spends one idle cycle, reads the byte at the program counter, and then spends two idle cycles. The program counter advances by one. A and carry update as in R4.
- R7: Push (0x05) increments SP first. It then spends two idle cycles before writing A at the new SP, so the write lands at the old SP plus one.
- R8: Pop (0x06) spends one idle cycle, reads at SP, and then spends two idle cycles. A takes the byte and SP drops by one.
- R9: Call (0x07) reads the target address and then pushes the return address, which is the address after the operand. The low byte goes to SP+1 and the high byte to SP+2, each write preceded by two idle cycles. SP ends two higher, and two idle cycles follow before execution continues at the target.
- R10: Return (0x08) reads the high byte at SP and then the low byte at SP-1. Each read is preceded by one idle cycle and followed by two idle cycles. SP ends two lower, and execution resumes at the rebuilt address.
- R11: Any opcode outside 0x01..0x08 uses only the four fetch cycles, causes no further bus activity, and leaves A, carry and SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Read data, valid the cycle after the read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| carry | output | 1 | Carry from the most recent add |

## Verification
The hardest situation to reach from the ports is a nested call. In a nested call, the stack holds two return addresses whose byte order must survive two pushes and two unwinding reads. The stimulus program therefore calls a routine that itself calls a deeper routine. Each routine returns in turn, and pushes and pops are placed around the calls so that SP arithmetic is checked at every depth. An add with a carry out, an add without one, and two undefined opcodes are placed in the same stream so that carry retention and the do-nothing path are seen between real instructions.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter logic [15:0] SP_INIT = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        carry
);

  localparam logic [7:0] OP_LDA = 8'h01;
  localparam logic [7:0] OP_STA = 8'h02;
  localparam logic [7:0] OP_ADD = 8'h03;
  localparam logic [7:0] OP_ADI = 8'h04;
  localparam logic [7:0] OP_PSH = 8'h05;
  localparam logic [7:0] OP_POP = 8'h06;
  localparam logic [7:0] OP_CAL = 8'h07;
  localparam logic [7:0] OP_RET = 8'h08;

  typedef enum logic [5:0] {
    F0, F1, F2, F3,
    P0, P1, P2, P3,
    M0, M1,
    R0, R1, R2,
    X0,
    W0, W1,
    U0, U1, U2,
    O0,
    C0, C1, C2, C3, C4, C5, C6, C7,
    E0, E1, E2, E3, E4, E5, E6, E7
  } step_t;

  step_t       st;
  logic [7:0]  a, ir, mdr;
  logic [15:0] pc, sp, t, mar;
  logic        hi, c;
  logic [8:0]  sum;

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign carry     = c;
  assign sum       = {1'b0, a} + {1'b0, mdr};

  assign mem_rd = (st == F1) || (st == P1) || (st == R0) || (st == E1) || (st == E5);
  assign mem_wr = (st == W1) || (st == U2) || (st == C2) || (st == C5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= F0;
      a   <= 8'h00;
      ir  <= 8'h00;
      mdr <= 8'h00;
      pc  <= 16'h0000;
      sp  <= SP_INIT;
      t   <= 16'h0000;
      mar <= 16'h0000;
      hi  <= 1'b0;
      c   <= 1'b0;
    end else begin
      case (st)
        F0: begin
          mar <= pc;
          pc  <= pc + 16'd1;
          st  <= F1;
        end
        F1: st <= F2;
        F2: begin
          mdr <= mem_rdata;
          st  <= F3;
        end
        F3: begin
          ir <= mdr;
          case (mdr)
            OP_LDA, OP_STA, OP_ADD, OP_CAL: st <= P0;
            OP_ADI: st <= X0;
            OP_PSH: st <= U0;
            OP_POP: st <= O0;
            OP_RET: st <= E0;
            default: st <= F0;
          endcase
        end
        P0: begin
          mar <= pc;
          pc  <= pc + 16'd1;
          st  <= P1;
        end
        P1: st <= P2;
        P2: begin
          mdr <= mem_rdata;
          st  <= P3;
        end
        P3: begin
          t <= {mdr, t[15:8]};
          if (!hi) begin
            hi <= 1'b1;
            st <= P0;
          end else begin
            hi <= 1'b0;
            st <= (ir == OP_CAL) ? C0 : M0;
          end
        end
        M0: begin
          mar[7:0] <= t[7:0];
          st <= M1;
        end
        M1: begin
          mar[15:8] <= t[15:8];
          st <= (ir == OP_STA) ? W0 : R0;
        end
        R0: st <= R1;
        R1: begin
          mdr <= mem_rdata;
          st  <= R2;
        end
        R2: begin
          if (ir == OP_ADD || ir == OP_ADI) begin
            a <= sum[7:0];
            c <= sum[8];
          end else begin
            a <= mdr;
          end
          st <= F0;
        end
        X0: begin
          mar <= pc;
          pc  <= pc + 16'd1;
          st  <= R0;
        end
        W0: begin
          mdr <= a;
          st  <= W1;
        end
        W1: st <= F0;
        U0: begin
          sp <= sp + 16'd1;
          st <= U1;
        end
        U1: begin
          mar <= sp;
          mdr <= a;
          st  <= U2;
        end
        U2: st <= F0;
        O0: begin
          mar <= sp;
          sp  <= sp - 16'd1;
          st  <= R0;
        end
        C0: begin
          sp <= sp + 16'd1;
          st <= C1;
        end
        C1: begin
          mar <= sp;
          mdr <= pc[7:0];
          st  <= C2;
        end
        C2: st <= C3;
        C3: begin
          sp <= sp + 16'd1;
          st <= C4;
        end
        C4: begin
          mar <= sp;
          mdr <= pc[15:8];
          st  <= C5;
        end
        C5: st <= C6;
        C6: begin
          pc[7:0] <= t[7:0];
          st <= C7;
        end
        C7: begin
          pc[15:8] <= t[15:8];
          st <= F0;
        end
        E0: begin
          mar <= sp;
          sp  <= sp - 16'd1;
          st  <= E1;
        end
        E1: st <= E2;
        E2: begin
          mdr <= mem_rdata;
          st  <= E3;
        end
        E3: begin
          pc[15:8] <= mdr;
          st <= E4;
        end
        E4: begin
          mar <= sp;
          sp  <= sp - 16'd1;
          st  <= E5;
        end
        E5: st <= E6;
        E6: begin
          mdr <= mem_rdata;
          st  <= E7;
        end
        E7: begin
          pc[7:0] <= mdr;
          st <= F0;
        end
        default: st <= F0;
      endcase
    end
  end

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F1) |-> (pc == mem_addr + 16'd1));

  p_stack_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && st != W1) |-> (mem_addr == sp));

  p_pop_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R0 && ir == OP_POP) |-> (sp == mem_addr - 16'd1));

  p_ret_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E5) |-> (mem_addr == sp + 16'd1));

  p_carry_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != R2) |=> $stable(carry));

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;
  logic        mem_rd, mem_wr, carry;

  always #10 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .carry(carry)
  );

  bit [7:0] mem [int];
  bit [7:0] ref_mem [int];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[int'(mem_addr)];
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  typedef struct {
    bit        rd;
    bit        wr;
    bit [15:0] addr;
    bit [7:0]  data;
    bit        chkc;
    bit        c;
    string     tag;
  } ent_t;

  ent_t q[$];
  int checks = 0;
  int errors = 0;

  bit [15:0] m_pc, m_sp;
  bit [7:0]  m_a;
  bit        m_c;

  task automatic poke(input int ad, input bit [7:0] v);
    mem[ad] = v;
    ref_mem[ad] = v;
  endtask

  function automatic bit [7:0] rdm(input bit [15:0] ad);
    return ref_mem.exists(int'(ad)) ? ref_mem[int'(ad)] : 8'h00;
  endfunction

  task automatic add(input bit rd, input bit wr, input bit [15:0] ad,
                     input bit [7:0] d, input bit chkc, input string tag);
    ent_t e;
    e.rd = rd; e.wr = wr; e.addr = ad; e.data = d;
    e.chkc = chkc; e.c = m_c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    add(0, 0, 16'h0, 8'h0, 0, tag);
  endtask

  task automatic byte_at_pc(input string tag, output bit [7:0] v);
    idle(tag);
    add(1, 0, m_pc, 8'h0, 0, tag);
    idle(tag);
    idle(tag);
    v = rdm(m_pc);
    m_pc = m_pc + 16'd1;
  endtask

  task automatic model_step();
    bit [7:0] op, lo, hb, v;
    bit [15:0] ea;
    bit [8:0] s;
    op = rdm(m_pc);
    add(0, 0, 16'h0, 8'h0, 1, (op >= 8'h01 && op <= 8'h08) ? "R2" : "R11");
    add(1, 0, m_pc, 8'h0, 0, "R2");
    idle("R2");
    idle("R2");
    m_pc = m_pc + 16'd1;
    case (op)
      8'h01, 8'h02, 8'h03: begin
        byte_at_pc("R3", lo);
        byte_at_pc("R3", hb);
        ea = {hb, lo};
        idle("R3");
        idle("R3");
        if (op == 8'h02) begin
          idle("R5");
          add(0, 1, ea, m_a, 0, "R5");
          ref_mem[int'(ea)] = m_a;
        end else begin
          add(1, 0, ea, 8'h0, 0, "R4");
          idle("R4");
          idle("R4");
          v = rdm(ea);
          if (op == 8'h01) m_a = v;
          else begin
            s = {1'b0, m_a} + {1'b0, v};
            m_a = s[7:0];
            m_c = s[8];
          end
        end
      end
      8'h04: begin
        idle("R6");
        add(1, 0, m_pc, 8'h0, 0, "R6");
        idle("R6");
        idle("R6");
        s = {1'b0, m_a} + {1'b0, rdm(m_pc)};
        m_a = s[7:0];
        m_c = s[8];
        m_pc = m_pc + 16'd1;
      end
      8'h05: begin
        m_sp = m_sp + 16'd1;
        idle("R7");
        idle("R7");
        add(0, 1, m_sp, m_a, 0, "R7");
        ref_mem[int'(m_sp)] = m_a;
      end
      8'h06: begin
        idle("R8");
        add(1, 0, m_sp, 8'h0, 0, "R8");
        idle("R8");
        idle("R8");
        m_a = rdm(m_sp);
        m_sp = m_sp - 16'd1;
      end
      8'h07: begin
        byte_at_pc("R9", lo);
        byte_at_pc("R9", hb);
        m_sp = m_sp + 16'd1;
        idle("R9");
        idle("R9");
        add(0, 1, m_sp, m_pc[7:0], 0, "R9");
        ref_mem[int'(m_sp)] = m_pc[7:0];
        m_sp = m_sp + 16'd1;
        idle("R9");
        idle("R9");
        add(0, 1, m_sp, m_pc[15:8], 0, "R9");
        ref_mem[int'(m_sp)] = m_pc[15:8];
        idle("R9");
        idle("R9");
        m_pc = {hb, lo};
      end
      8'h08: begin
        idle("R10");
        add(1, 0, m_sp, 8'h0, 0, "R10");
        idle("R10");
        idle("R10");
        hb = rdm(m_sp);
        m_sp = m_sp - 16'd1;
        idle("R10");
        add(1, 0, m_sp, 8'h0, 0, "R10");
        idle("R10");
        idle("R10");
        lo = rdm(m_sp);
        m_sp = m_sp - 16'd1;
        m_pc = {hb, lo};
      end
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input ent_t e);
    check(mem_rd === e.rd && mem_wr === e.wr, e.tag, "strobes",
          int'({mem_rd, mem_wr}), int'({e.rd, e.wr}));
    if (e.rd || e.wr)
      check(mem_addr === e.addr, e.tag, "address", int'(mem_addr), int'(e.addr));
    if (e.wr)
      check(mem_wdata === e.data, e.tag, "write data", int'(mem_wdata), int'(e.data));
    if (e.chkc)
      check(carry === e.c, e.tag, "carry", int'(carry), int'(e.c));
  endtask

  task automatic load_program();
    byte prog [] = '{8'h04, 8'h05, 8'h01, 8'h00, 8'h10, 8'h03, 8'h01, 8'h10,
                     8'h02, 8'h00, 8'h20, 8'h05, 8'h04, 8'h01, 8'h06,
                     8'h07, 8'h00, 8'h03, 8'h02, 8'h01, 8'h20, 8'hFF, 8'h00,
                     8'h02, 8'h02, 8'h20, 8'h07, 8'h00, 8'h04,
                     8'h04, 8'hFF, 8'h02, 8'h04, 8'h20, 8'h06};
    byte s3 [] = '{8'h04, 8'h7F, 8'h05, 8'h06, 8'h08};
    byte s4 [] = '{8'h07, 8'h00, 8'h05, 8'h08};
    byte s5 [] = '{8'h04, 8'h80, 8'h02, 8'h03, 8'h20, 8'h08};
    foreach (prog[i]) poke(i, prog[i]);
    foreach (s3[i]) poke(16'h0300 + i, s3[i]);
    foreach (s4[i]) poke(16'h0400 + i, s4[i]);
    foreach (s5[i]) poke(16'h0500 + i, s5[i]);
    poke(16'h1000, 8'hF0);
    poke(16'h1001, 8'h20);
  endtask

  initial begin
    ent_t e;
    load_program();
    m_pc = 16'h0000;
    m_sp = 16'hFF00;
    m_a = 8'h00;
    m_c = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_rd === 1'b0 && mem_wr === 1'b0, "R1", "strobes in reset",
          int'({mem_rd, mem_wr}), 0);
    check(carry === 1'b0, "R1", "carry in reset", int'(carry), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 32; n++) begin
      model_step();
      while (q.size() > 0) begin
        e = q.pop_front();
        #1;
        compare(e);
        @(negedge clk);
      end
    end
    check(mem[16'h2000] == 8'h10, "R5", "store of carried sum",
          int'(mem[16'h2000]), 8'h10);
    check(mem[16'hFF01] == ref_mem[16'hFF01], "R9", "stack low byte",
          int'(mem[16'hFF01]), int'(ref_mem[16'hFF01]));
    check(mem[16'hFF02] == ref_mem[16'hFF02], "R9", "stack high byte",
          int'(mem[16'hFF02]), int'(ref_mem[16'hFF02]));
    for (int ad = 16'h2000; ad <= 16'h2004; ad++)
      check(mem[ad] == ref_mem[ad], "R5", "stored byte", int'(mem[ad]), int'(ref_mem[ad]));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule